// File: doc/BRIEF.md
# Timer Compare Output Unit

This unit holds a free-running up-counter and a compare value of the same width. On every clock it checks whether the two are equal and, if so, acts according to a 4-bit mode held in a register. Depending on the mode, a match can do one of three things. It can drive an output latch high. It can drive the latch low. It can leave the latch alone and only raise a sticky interrupt flag. It can also restart the counter from zero and emit a one-cycle pulse that starts an external conversion, which turns the compare value into the counter's period.

Software reaches two registers through a single write port: the mode register and the compare register. The counter counts only while its run input is high. Each time it wraps from all ones to zero it sets a sticky overflow flag. A restart caused by a period match never sets that flag.

The output latch keeps one deliberate quirk. Moving the mode from clear-on-match straight to set-on-match flips a hidden invert bit, and that bit is XORed onto the pin from then on until reset. The pin is driven only when the output-enable request is high and the mode is one of the two pin-driving modes. In every other case it reads as zero.

Top module: `match_out_unit`

## Requirements
- R1: While `tmr_run` is high the counter `tmr_q` increases by one per clock, and while it is low the counter holds its value. A step from all ones to zero sets `ovf_flag`, which stays set until an `ovf_clr` pulse.
- R2: A match is `tmr_q == compare` with a nonzero mode. Every match sets `cmp_flag` on the next clock whatever the mode. The flag stays set until `flag_clr`, and a set in the same cycle as a clear wins.
- R3: In mode 4'b1000 (set-on-match) a match drives the output latch high.
- R4: In mode 4'b1001 (clear-on-match) a match drives the output latch low.
- R5: In mode 4'b1010 (software-interrupt) a match leaves the output latch unchanged and only sets `cmp_flag`.
- R6: In mode 4'b1011 (period/trigger) a match loads the counter with zero on the next clock and raises `conv_start` for exactly that one cycle.
- R7: A counter restart caused by R6 never sets `ovf_flag`, even when the compare value is all ones.
- R8: Writing mode 4'b0000 forces the output latch low. Mode 4'b0000 is off: no match, no flag, no latch action.
- R9: A mode write of 4'b1000 while the mode is 4'b1001 toggles an invert bit. That bit is XORed onto the pin for all later compares and is cleared only by reset.
- R10: `pin_oe` is high only when `oe_req` is high and the mode is 4'b1000 or 4'b1001. When `pin_oe` is low, `pin_out` is 0.
- R11: A write with `wr_addr` = 0 loads the mode from `wr_data[3:0]`. A write with `wr_addr` = 1 loads the compare value from `wr_data`. Both take effect on the following clock.
- R12: After reset the counter, compare value, mode, latch, invert bit and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = mode register, 1 = compare register |
| wr_data | input | TMR_W | Write data |
| tmr_run | input | 1 | Counter enable |
| oe_req | input | 1 | Output-enable request for the pin |
| flag_clr | input | 1 | Clears the compare flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| pin_out | output | 1 | Compare output pin value |
| pin_oe | output | 1 | Compare output pin enable |
| cmp_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky counter-wrap flag |
| conv_start | output | 1 | One-cycle conversion start pulse |
| tmr_q | output | TMR_W | Current counter value |

## Verification
Some rules hold on every clock, and properties watch them continuously. Any match sets the flag. Each mode acts on the latch in its own way. A period match zeroes the counter and produces the pulse without an overflow. A zero-mode write clears the latch. The invert bit changes only on the clear-to-set transition. An undriven pin reads zero. Other behaviour can only be shown by the bench's ordered scenarios. One is that a software-interrupt match really left an earlier high latch intact, which is seen after switching back to a driving mode. Another is that the inversion persists across a later match, and a third is the natural wrap against a period match at all ones.

// File: rtl/mou_pkg.sv
// Shared constants for the timer compare output unit.
// Assumes the mode field is always four bits wide.
package mou_pkg;
    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MD_OFF  = 4'b0000;
    localparam logic [MODE_W-1:0] MD_SET  = 4'b1000;
    localparam logic [MODE_W-1:0] MD_CLR  = 4'b1001;
    localparam logic [MODE_W-1:0] MD_SOFT = 4'b1010;
    localparam logic [MODE_W-1:0] MD_EVT  = 4'b1011;

    localparam logic ADDR_MODE = 1'b0;
    localparam logic ADDR_CMP  = 1'b1;

    // True for the two modes that own the output pin.
    function automatic logic mode_drives_pin(logic [MODE_W-1:0] m);
        return (m == MD_SET) || (m == MD_CLR);
    endfunction
endpackage

// File: rtl/mou_timer.sv
// Up-counter with enable, period restart and sticky wrap flag.
// Assumes evt_clr is a single-cycle request; a restart overrides counting
// and suppresses the wrap flag on the same edge.
module mou_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             evt_clr,
    input  logic             ovf_clr,
    output logic [TMR_W-1:0] cnt_q,
    output logic             ovf_q
);
    localparam logic [TMR_W-1:0] CNT_MAX = {TMR_W{1'b1}};

    logic wrap;

    // Natural wrap: counting from all ones, no restart on this edge.
    always_comb wrap = run && (cnt_q == CNT_MAX) && !evt_clr;

    // Counter register: restart, count or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (evt_clr)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + 1'b1;
    end

    // Sticky overflow flag; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (wrap)
            ovf_q <= 1'b1;
        else if (ovf_clr)
            ovf_q <= 1'b0;
    end
endmodule

// File: rtl/mou_regs.sv
// Mode and compare registers behind one write port, plus the invert bit
// that flips on a direct clear-to-set mode change.
// Assumes TMR_W >= MODE_W so the mode fits in the low write-data bits.
module mou_regs
    import mou_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [TMR_W-1:0]  wr_data,
    output logic [MODE_W-1:0] mode_q,
    output logic [TMR_W-1:0]  cmp_q,
    output logic              zero_wr,
    output logic              inv_tgl,
    output logic              inv_q
);
    logic              mode_wr;
    logic              cmp_wr;
    logic [MODE_W-1:0] mode_nx;

    // Decode the write strobe and the candidate mode.
    always_comb begin
        mode_wr = wr_en && (wr_addr == ADDR_MODE);
        cmp_wr  = wr_en && (wr_addr == ADDR_CMP);
        mode_nx = wr_data[MODE_W-1:0];
        zero_wr = mode_wr && (mode_nx == MD_OFF);
        inv_tgl = mode_wr && (mode_q == MD_CLR) && (mode_nx == MD_SET);
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MD_OFF;
        else if (mode_wr)
            mode_q <= mode_nx;
    end

    // Compare register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (cmp_wr)
            cmp_q <= wr_data;
    end

    // Invert bit: toggles on the clear-to-set change, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            inv_q <= 1'b0;
        else if (inv_tgl)
            inv_q <= ~inv_q;
    end
endmodule

// File: rtl/mou_match.sv
// Equality compare and match actions: output latch, compare flag and
// conversion pulse. Assumes the mode and compare value are registered.
module mou_match
    import mou_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  cnt_q,
    input  logic [TMR_W-1:0]  cmp_q,
    input  logic [MODE_W-1:0] mode_q,
    input  logic              zero_wr,
    input  logic              flag_clr,
    output logic              cmp_hit,
    output logic              evt_hit,
    output logic              out_latch,
    output logic              flag_q,
    output logic              conv_q
);
    // Match detect; the off mode never matches.
    always_comb begin
        cmp_hit = (cnt_q == cmp_q) && (mode_q != MD_OFF);
        evt_hit = cmp_hit && (mode_q == MD_EVT);
    end

    // Output latch: a zero-mode write clears it, else driving modes act on a match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_latch <= 1'b0;
        else if (zero_wr)
            out_latch <= 1'b0;
        else if (cmp_hit && (mode_q == MD_SET))
            out_latch <= 1'b1;
        else if (cmp_hit && (mode_q == MD_CLR))
            out_latch <= 1'b0;
    end

    // Sticky compare flag; a match beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (cmp_hit)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    // Conversion pulse, one cycle per period match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            conv_q <= 1'b0;
        else
            conv_q <= evt_hit;
    end
endmodule

// File: rtl/match_out_unit.sv
// Top level of the timer compare output unit. Wires the register block,
// counter and match logic together and forms the pin.
// Assumes TMR_W >= 4.
module match_out_unit
    import mou_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    input  logic             tmr_run,
    input  logic             oe_req,
    input  logic             flag_clr,
    input  logic             ovf_clr,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             cmp_flag,
    output logic             ovf_flag,
    output logic             conv_start,
    output logic [TMR_W-1:0] tmr_q
);
    logic [MODE_W-1:0] mode_q;
    logic [TMR_W-1:0]  cmp_q;
    logic              zero_wr;
    logic              inv_tgl;
    logic              inv_q;
    logic              cmp_hit;
    logic              evt_hit;
    logic              out_latch;

    mou_regs #(.TMR_W(TMR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode_q  (mode_q),
        .cmp_q   (cmp_q),
        .zero_wr (zero_wr),
        .inv_tgl (inv_tgl),
        .inv_q   (inv_q)
    );

    mou_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .evt_clr (evt_hit),
        .ovf_clr (ovf_clr),
        .cnt_q   (tmr_q),
        .ovf_q   (ovf_flag)
    );

    mou_match #(.TMR_W(TMR_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_q     (tmr_q),
        .cmp_q     (cmp_q),
        .mode_q    (mode_q),
        .zero_wr   (zero_wr),
        .flag_clr  (flag_clr),
        .cmp_hit   (cmp_hit),
        .evt_hit   (evt_hit),
        .out_latch (out_latch),
        .flag_q    (cmp_flag),
        .conv_q    (conv_start)
    );

    // Pin: driven only in the two driving modes with the request high.
    always_comb begin
        pin_oe  = oe_req && mode_drives_pin(mode_q);
        pin_out = pin_oe && (out_latch ^ inv_q);
    end
endmodule

// File: rtl/match_out_unit_chk.sv
// Property checker for match_out_unit, attached with bind below.
module match_out_unit_chk
    import mou_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tmr_run,
    input logic              flag_clr,
    input logic              pin_out,
    input logic              pin_oe,
    input logic              cmp_flag,
    input logic              ovf_flag,
    input logic              conv_start,
    input logic [TMR_W-1:0]  tmr_q,
    input logic [MODE_W-1:0] mode_q,
    input logic              zero_wr,
    input logic              inv_tgl,
    input logic              inv_q,
    input logic              cmp_hit,
    input logic              out_latch
);
    localparam logic [TMR_W-1:0] ALL_ONES = {TMR_W{1'b1}};

    // R1: a natural wrap zeroes the counter and raises the overflow flag.
    a_r1_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_run && tmr_q == ALL_ONES && !(cmp_hit && mode_q == MD_EVT))
        |=> (ovf_flag && tmr_q == '0));

    // R2: any match raises the compare flag.
    a_r2_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |=> cmp_flag);

    // R2: the flag holds without a clear.
    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !flag_clr) |=> cmp_flag);

    // R3: set-on-match drives the latch high.
    a_r3_set_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && mode_q == MD_SET && !zero_wr) |=> out_latch);

    // R4: clear-on-match drives the latch low.
    a_r4_clr_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && mode_q == MD_CLR) |=> !out_latch);

    // R5: software-interrupt matches leave the latch alone.
    a_r5_soft_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && mode_q == MD_SOFT && !zero_wr) |=> $stable(out_latch));

    // R6: a period match restarts the counter and pulses the trigger.
    a_r6_evt_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && mode_q == MD_EVT) |=> (tmr_q == '0 && conv_start));

    // R6: the trigger never fires without a period match.
    a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(cmp_hit && mode_q == MD_EVT));

    // R7: a period restart does not raise the overflow flag.
    a_r7_no_ovf_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && mode_q == MD_EVT && !ovf_flag) |=> !ovf_flag);

    // R8: a zero-mode write clears the latch.
    a_r8_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wr |=> !out_latch);

    // R9: the invert bit flips on the clear-to-set change ...
    a_r9_inv_flip: assert property (@(posedge clk) disable iff (!rst_n)
        inv_tgl |=> (inv_q != $past(inv_q)));

    // R9: ... and holds otherwise.
    a_r9_inv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_tgl |=> $stable(inv_q));

    // R10: an undriven pin reads zero.
    a_r10_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_out);
endmodule

bind match_out_unit match_out_unit_chk #(.TMR_W(TMR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_run    (tmr_run),
    .flag_clr   (flag_clr),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .cmp_flag   (cmp_flag),
    .ovf_flag   (ovf_flag),
    .conv_start (conv_start),
    .tmr_q      (tmr_q),
    .mode_q     (mode_q),
    .zero_wr    (zero_wr),
    .inv_tgl    (inv_tgl),
    .inv_q      (inv_q),
    .cmp_hit    (cmp_hit),
    .out_latch  (out_latch)
);

// File: tb/match_out_unit_tb.sv
// Scoreboard bench: driver tasks queue expected port values, a monitor
// process pops and compares them against the live outputs.
module match_out_unit_tb;
    localparam int TW = 16;
    localparam int K_PIN = 0, K_OE = 1, K_FLAG = 2, K_OVF = 3, K_CONV = 4, K_TMR = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [TW-1:0] wr_data = '0;
    logic          tmr_run = 1'b0;
    logic          oe_req = 1'b0;
    logic          flag_clr = 1'b0;
    logic          ovf_clr = 1'b0;
    logic          pin_out, pin_oe, cmp_flag, ovf_flag, conv_start;
    logic [TW-1:0] tmr_q;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        int            kind;
        logic [TW-1:0] exp;
        string         req;
    } item_t;
    item_t sb[$];
    event  do_check;

    always #2.5 clk = ~clk;

    match_out_unit #(.TMR_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tmr_run(tmr_run), .oe_req(oe_req),
        .flag_clr(flag_clr), .ovf_clr(ovf_clr), .pin_out(pin_out),
        .pin_oe(pin_oe), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
        .conv_start(conv_start), .tmr_q(tmr_q)
    );

    function automatic logic [TW-1:0] observe(int k);
        case (k)
            K_PIN:   return {{(TW-1){1'b0}}, pin_out};
            K_OE:    return {{(TW-1){1'b0}}, pin_oe};
            K_FLAG:  return {{(TW-1){1'b0}}, cmp_flag};
            K_OVF:   return {{(TW-1){1'b0}}, ovf_flag};
            K_CONV:  return {{(TW-1){1'b0}}, conv_start};
            default: return tmr_q;
        endcase
    endfunction

    // Monitor: pops every queued expectation and compares it.
    initial begin
        forever begin
            @(do_check);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                tests++;
                if (observe(it.kind) !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h",
                             it.req, it.kind, observe(it.kind), it.exp);
                end
            end
        end
    end

    task automatic expect_val(int k, logic [TW-1:0] v, string req);
        item_t it;
        it.kind = k; it.exp = v; it.req = req;
        sb.push_back(it);
    endtask

    task automatic check_now();
        -> do_check;
        #1;
    endtask

    task automatic write_reg(logic a, logic [TW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_flag_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic wait_tmr(logic [TW-1:0] v);
        for (int i = 0; i < 70000; i++) begin
            if (tmr_q == v) return;
            @(negedge clk);
        end
    endtask

    // Stop the counter, place the compare point ahead, clear the flag,
    // run until the match, then step past the edge that acts on it.
    task automatic arm_match(logic [TW-1:0] target);
        tmr_run = 1'b0;
        write_reg(1'b1, target);
        pulse_flag_clr();
        tmr_run = 1'b1;
        wait_tmr(target);
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        expect_val(K_TMR, '0, "R12 timer");
        expect_val(K_FLAG, 0, "R12 cmp_flag");
        expect_val(K_OVF, 0, "R12 ovf_flag");
        expect_val(K_CONV, 0, "R12 conv_start");
        expect_val(K_PIN, 0, "R12 pin_out");
        check_now();

        // R1 hold while stopped
        hold = tmr_q;
        repeat (3) @(negedge clk);
        expect_val(K_TMR, hold, "R1 hold when stopped");
        check_now();

        // R11/R10 mode write, pin enabled in set mode
        oe_req = 1'b1;
        write_reg(1'b0, 16'h0008);
        expect_val(K_OE, 1, "R10 oe in set mode");
        expect_val(K_PIN, 0, "R11 latch low before match");
        check_now();

        // R1 counting
        tmr_run = 1'b1;
        repeat (4) @(negedge clk);
        expect_val(K_TMR, 16'd4, "R1 counts");
        check_now();

        // R3 set-on-match
        arm_match(tmr_q + 16'd3);
        expect_val(K_PIN, 1, "R3 set drives high");
        expect_val(K_FLAG, 1, "R2 flag on match");
        check_now();

        // R2 clear
        pulse_flag_clr();
        expect_val(K_FLAG, 0, "R2 flag cleared");
        check_now();

        // R5 software mode leaves latch high
        tmr_run = 1'b0;
        write_reg(1'b0, 16'h000A);
        expect_val(K_OE, 0, "R10 oe off in soft mode");
        expect_val(K_PIN, 0, "R10 pin zero when undriven");
        check_now();
        arm_match(tmr_q + 16'd3);
        expect_val(K_FLAG, 1, "R5 flag in soft mode");
        check_now();
        tmr_run = 1'b0;
        write_reg(1'b0, 16'h0008);
        expect_val(K_PIN, 1, "R5 latch unchanged");
        check_now();

        // R8 zero write forces low; off mode gives no flag
        write_reg(1'b0, 16'h0000);
        expect_val(K_OE, 0, "R10 oe off in off mode");
        check_now();
        arm_match(tmr_q + 16'd3);
        expect_val(K_FLAG, 0, "R8 no flag when off");
        check_now();
        tmr_run = 1'b0;
        write_reg(1'b0, 16'h0008);
        expect_val(K_PIN, 0, "R8 latch forced low");
        check_now();

        // R3 again then R4 clear-on-match
        arm_match(tmr_q + 16'd3);
        expect_val(K_PIN, 1, "R3 set after zero");
        check_now();
        tmr_run = 1'b0;
        write_reg(1'b0, 16'h0009);
        expect_val(K_PIN, 1, "R4 latch kept until match");
        check_now();
        arm_match(tmr_q + 16'd3);
        expect_val(K_PIN, 0, "R4 clear drives low");
        expect_val(K_FLAG, 1, "R2 flag in clear mode");
        check_now();

        // R9 clear-to-set change inverts the pin, and it persists
        tmr_run = 1'b0;
        write_reg(1'b0, 16'h0008);
        expect_val(K_PIN, 1, "R9 inverted after 1001->1000");
        check_now();
        arm_match(tmr_q + 16'd3);
        expect_val(K_PIN, 0, "R9 inversion persists on match");
        check_now();

        // R1 natural wrap sets overflow (off mode)
        tmr_run = 1'b0;
        write_reg(1'b0, 16'h0000);
        tmr_run = 1'b1;
        wait_tmr(16'hFFFF);
        @(negedge clk);
        expect_val(K_TMR, 16'h0000, "R1 wrap to zero");
        expect_val(K_OVF, 1, "R1 overflow on wrap");
        check_now();
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        expect_val(K_OVF, 0, "R1 overflow cleared");
        check_now();

        // R6 period match restarts the counter and pulses once
        tmr_run = 1'b0;
        write_reg(1'b0, 16'h000B);
        arm_match(tmr_q + 16'd5);
        expect_val(K_TMR, 16'h0000, "R6 counter restarted");
        expect_val(K_CONV, 1, "R6 trigger pulse");
        expect_val(K_FLAG, 1, "R2 flag in period mode");
        check_now();
        @(negedge clk);
        expect_val(K_CONV, 0, "R6 pulse one cycle");
        expect_val(K_TMR, 16'h0001, "R6 counts after restart");
        check_now();

        // R7 period match at all ones: no overflow
        arm_match(16'hFFFF);
        expect_val(K_TMR, 16'h0000, "R7 restart at all ones");
        expect_val(K_OVF, 0, "R7 no overflow on restart");
        expect_val(K_CONV, 1, "R7 trigger at all ones");
        check_now();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule